// File: doc/BRIEF.md
# I2C Data-Register DMA Handshake

This block sits between the byte engine of an I2C controller and one DMA channel. The byte engine reports two events: the data register has handed its byte to the shifter (transmit), or a received byte has landed in it (receive). The block keeps an empty flag and a full flag for those events. While DMA is enabled, it turns the flag that matches the current direction into a level request. The request stays up until the DMA channel writes or reads the data register. Events raised during address or control phases never set a flag, so only data bytes are moved by DMA.

The block also takes the channel's two completion strobes. The final-count strobe sets a sticky transfer-complete flag, which can raise an interrupt. The count-minus-one strobe matters only when receiving with the last-transfer option set: it arms an automatic NACK. The acknowledge level handed to the byte engine is registered. It is reloaded at the start of every received byte, so the byte after the count-minus-one strobe is refused.

A software STOP request is held pending until it is safe to issue. In transmit mode that means DMA is switched off and the engine reports the byte as finished. In receive mode it is issued at once.

Top module: `i2c_dma_hs`

## Requirements
- R1: `dr_empty` rises on the clock after `dr_empty_ev` while `data_phase`=1 and `cfg_rx`=0, and falls on the clock after `dma_wr`; when both occur in one cycle the flag ends set. It resets to 0.
- R2: `dr_full` rises on the clock after `dr_full_ev` while `data_phase`=1 and `cfg_rx`=1, and falls on the clock after `dma_rd`; when both occur in one cycle the flag ends set. It resets to 0.
- R3: `dma_req` equals `cfg_dma_en` AND (`dr_full` when `cfg_rx`=1, else `dr_empty`), with no register in between. Clearing `cfg_dma_en` therefore removes a pending request in the same cycle, and the flag stays set.
- R4: A `dr_empty_ev` or `dr_full_ev` with `data_phase`=0, or one that does not match the current direction, changes neither flag.
- R5: `dma_eot` sets `tc_flag` on the next clock. `sw_tc_clr` clears it, and a simultaneous `dma_eot` wins. `tc_irq` equals `tc_flag` AND `cfg_tc_ie`.
- R6: A `dma_eot_m1` strobe while `cfg_rx`=1 and `cfg_last`=1 arms a NACK. The next `rx_byte_start` after the strobe cycle loads `ack_out`=0 (1 means ACK) and disarms. A byte start in the same cycle as the strobe does not consume it.
- R7: A `dma_eot_m1` strobe with `cfg_last`=0 or `cfg_rx`=0 has no effect: `ack_out` keeps loading `cfg_ack` at each `rx_byte_start`.
- R8: `ack_out` changes only on the clock after an `rx_byte_start`, and it resets to 0.
- R9: `sw_stop` makes a STOP pending. `stop_go` is high while it is pending and allowed (`cfg_rx`=1, or `cfg_dma_en`=0 with `byte_done`=1). The pending state clears on the clock after `stop_go` unless `sw_stop` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dma_en | input | 1 | DMA enable control bit |
| cfg_last | input | 1 | Last-transfer option: auto-NACK after the count-minus-one strobe |
| cfg_rx | input | 1 | Direction: 1 receive, 0 transmit |
| cfg_ack | input | 1 | Software acknowledge level for normal bytes (1 = ACK) |
| cfg_tc_ie | input | 1 | Transfer-complete interrupt enable |
| data_phase | input | 1 | Engine is in a data byte (not address/control) |
| dr_empty_ev | input | 1 | Engine pulse: data register emptied in transmit |
| dr_full_ev | input | 1 | Engine pulse: received byte placed in data register |
| dma_wr | input | 1 | DMA write of the data register |
| dma_rd | input | 1 | DMA read of the data register |
| dma_eot | input | 1 | DMA final-count strobe |
| dma_eot_m1 | input | 1 | DMA count-minus-one strobe |
| rx_byte_start | input | 1 | Engine pulse: a received byte is starting |
| byte_done | input | 1 | Engine: byte transfer finished |
| sw_stop | input | 1 | Software STOP request |
| sw_tc_clr | input | 1 | Software clear of transfer complete |
| dma_req | output | 1 | Level DMA request |
| dr_empty | output | 1 | Transmit data register empty flag |
| dr_full | output | 1 | Receive data register full flag |
| tc_flag | output | 1 | Sticky transfer-complete status |
| tc_irq | output | 1 | Transfer-complete interrupt |
| ack_out | output | 1 | Registered acknowledge level to the byte engine |
| stop_go | output | 1 | STOP issue strobe to the byte engine |

## Verification
The assertions check, on every cycle, the properties that involve one step of time. A DMA access clears its flag. Events outside data phases never raise a flag. Final-count strobes always leave the complete flag set. An armed NACK is loaded at the next byte start. The acknowledge level holds still between byte starts. A pending STOP is neither dropped nor repeated. Only the bench can show the longer orderings, because it drives whole sequences against a reference model. These include a count-minus-one strobe that coincides with a byte start and is carried to the following byte. They also include the acknowledge level returning to the software value afterwards, a transmit STOP waiting through several cycles until DMA is off and the byte is done, and requests vanishing and returning as the enable toggles.

// File: rtl/i2c_dma_hs.sv
module i2c_dma_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_dma_en,
  input  logic cfg_last,
  input  logic cfg_rx,
  input  logic cfg_ack,
  input  logic cfg_tc_ie,
  input  logic data_phase,
  input  logic dr_empty_ev,
  input  logic dr_full_ev,
  input  logic dma_wr,
  input  logic dma_rd,
  input  logic dma_eot,
  input  logic dma_eot_m1,
  input  logic rx_byte_start,
  input  logic byte_done,
  input  logic sw_stop,
  input  logic sw_tc_clr,
  output logic dma_req,
  output logic dr_empty,
  output logic dr_full,
  output logic tc_flag,
  output logic tc_irq,
  output logic ack_out,
  output logic stop_go
);

  logic empty_set, full_set, nack_arm, arm_set, stop_pend, stop_ok;

  assign empty_set = dr_empty_ev & data_phase & ~cfg_rx;
  assign full_set  = dr_full_ev  & data_phase &  cfg_rx;
  assign arm_set   = dma_eot_m1 & cfg_rx & cfg_last;
  assign stop_ok   = cfg_rx | (~cfg_dma_en & byte_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_empty  <= 1'b0;
      dr_full   <= 1'b0;
      tc_flag   <= 1'b0;
      nack_arm  <= 1'b0;
      ack_out   <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      dr_empty  <= empty_set | (dr_empty & ~dma_wr);
      dr_full   <= full_set  | (dr_full  & ~dma_rd);
      tc_flag   <= dma_eot   | (tc_flag  & ~sw_tc_clr);
      nack_arm  <= arm_set   | (nack_arm & ~rx_byte_start);
      if (rx_byte_start) ack_out <= nack_arm ? 1'b0 : cfg_ack;
      stop_pend <= sw_stop | (stop_pend & ~stop_go);
    end
  end

  assign dma_req = cfg_dma_en & (cfg_rx ? dr_full : dr_empty);
  assign tc_irq  = tc_flag & cfg_tc_ie;
  assign stop_go = stop_pend & stop_ok;

  p_wr_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr && !dr_empty_ev |=> !dr_empty);
  p_rd_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd && !dr_full_ev |=> !dr_full);
  p_req_gone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_dma_en) |-> !dma_req);
  p_ctrl_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |=> !$rose(dr_empty) && !$rose(dr_full));
  p_eot_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_eot |=> tc_flag);
  p_nack_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_start && nack_arm |=> !ack_out);
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_byte_start |=> $stable(ack_out));
  p_stop_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pend && !stop_go |=> stop_pend);
  p_stop_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go && !sw_stop |=> !stop_go);

endmodule

// File: tb/i2c_dma_hs_tb.sv
module i2c_dma_hs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dma_en, cfg_last, cfg_rx, cfg_ack, cfg_tc_ie, data_phase;
  logic dr_empty_ev, dr_full_ev, dma_wr, dma_rd, dma_eot, dma_eot_m1;
  logic rx_byte_start, byte_done, sw_stop, sw_tc_clr;
  logic dma_req, dr_empty, dr_full, tc_flag, tc_irq, ack_out, stop_go;

  int total = 0, bad = 0;
  bit done = 0;
  logic [6:0] expq[$];
  logic m_e, m_f, m_tc, m_arm, m_ack, m_pend;

  always #5 clk = ~clk;

  i2c_dma_hs u_dut (.*);

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    dr_empty_ev = 0; dr_full_ev = 0; dma_wr = 0; dma_rd = 0; dma_eot = 0;
    dma_eot_m1 = 0; rx_byte_start = 0; sw_stop = 0; sw_tc_clr = 0;
  endtask

  // driver: computes post-edge expectation from the requirements, then advances
  task automatic tick();
    logic ok, go_now;
    ok = cfg_rx | (~cfg_dma_en & byte_done);
    go_now = m_pend & ok;
    m_e   = (dr_empty_ev & data_phase & ~cfg_rx) | (m_e & ~dma_wr);
    m_f   = (dr_full_ev & data_phase & cfg_rx) | (m_f & ~dma_rd);
    m_tc  = dma_eot | (m_tc & ~sw_tc_clr);
    if (rx_byte_start) m_ack = m_arm ? 1'b0 : cfg_ack;
    m_arm = (dma_eot_m1 & cfg_rx & cfg_last) | (m_arm & ~rx_byte_start);
    m_pend = sw_stop | (m_pend & ~go_now);
    expq.push_back({cfg_dma_en & (cfg_rx ? m_f : m_e), m_e, m_f, m_tc,
                    m_tc & cfg_tc_ie, m_ack, m_pend & ok});
    @(negedge clk);
    idle();
  endtask

  // monitor
  initial forever begin
    @(posedge clk); #2;
    if (expq.size() > 0) begin
      logic [6:0] x;
      x = expq.pop_front();
      chk("R3 dma_req", dma_req, x[6]);
      chk("R1 dr_empty", dr_empty, x[5]);
      chk("R2 dr_full", dr_full, x[4]);
      chk("R5 tc_flag", tc_flag, x[3]);
      chk("R5 tc_irq", tc_irq, x[2]);
      chk("R6 ack_out", ack_out, x[1]);
      chk("R9 stop_go", stop_go, x[0]);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    cfg_dma_en = 0; cfg_last = 0; cfg_rx = 0; cfg_ack = 1; cfg_tc_ie = 0;
    data_phase = 1; byte_done = 0;
    {m_e, m_f, m_tc, m_arm, m_ack, m_pend} = '0;
    repeat (3) @(negedge clk);
    // R10-style reset state, checked per R1/R2/R3/R5/R8/R9
    chk("R1 reset dr_empty", dr_empty, 0);
    chk("R2 reset dr_full", dr_full, 0);
    chk("R3 reset dma_req", dma_req, 0);
    chk("R5 reset tc_flag", tc_flag, 0);
    chk("R8 reset ack_out", ack_out, 0);
    chk("R9 reset stop_go", stop_go, 0);
    rst_n = 1;

    // R1/R3 transmit flow
    cfg_dma_en = 1; dr_empty_ev = 1; tick();
    tick();
    cfg_dma_en = 0; tick();          // R3 request drops, flag kept
    cfg_dma_en = 1; tick();
    dma_wr = 1; tick();
    dma_wr = 1; dr_empty_ev = 1; tick(); // set wins
    dma_wr = 1; tick();
    // R4 control phase and wrong direction
    data_phase = 0; dr_empty_ev = 1; tick();
    data_phase = 1; dr_full_ev = 1; tick();
    // R2 receive flow
    cfg_rx = 1; dr_full_ev = 1; tick();
    tick();
    dma_rd = 1; dr_full_ev = 1; tick();
    dma_rd = 1; tick();
    data_phase = 0; dr_full_ev = 1; tick();
    data_phase = 1; dr_empty_ev = 1; tick();
    // R5 transfer complete
    cfg_tc_ie = 1; dma_eot = 1; tick();
    sw_tc_clr = 1; tick();
    dma_eot = 1; tick();
    dma_eot = 1; sw_tc_clr = 1; tick();
    cfg_tc_ie = 0; tick();
    sw_tc_clr = 1; tick();
    // R6 auto-NACK
    cfg_last = 1; rx_byte_start = 1; tick();
    dma_eot_m1 = 1; tick();
    tick();
    rx_byte_start = 1; tick();       // NACK byte
    rx_byte_start = 1; tick();       // back to cfg_ack
    dma_eot_m1 = 1; rx_byte_start = 1; tick(); // not consumed here
    rx_byte_start = 1; tick();
    // R7 no effect without last or in transmit
    cfg_last = 0; dma_eot_m1 = 1; tick();
    rx_byte_start = 1; tick();
    cfg_last = 1; cfg_rx = 0; dma_eot_m1 = 1; tick();
    cfg_rx = 1; rx_byte_start = 1; tick();
    cfg_ack = 0; rx_byte_start = 1; tick();
    cfg_ack = 1; tick();             // R8 hold without byte start
    // R9 stop handling
    cfg_rx = 0; cfg_dma_en = 1; byte_done = 1; sw_stop = 1; tick();
    tick();
    cfg_dma_en = 0; byte_done = 0; tick();
    byte_done = 1; tick();
    tick();
    cfg_rx = 1; sw_stop = 1; tick();
    tick();

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cfg_dma_en = r[0] | r[1]; cfg_last = r[2]; cfg_rx = r[3] & r[25];
      if (r[26]) cfg_rx = r[3];
      cfg_ack = r[4]; cfg_tc_ie = r[5]; data_phase = r[6] | r[7];
      dr_empty_ev = r[8]; dr_full_ev = r[9]; dma_wr = r[10] & r[11];
      dma_rd = r[12] & r[13]; dma_eot = r[14] & r[15] & r[16];
      dma_eot_m1 = r[17] & r[18]; rx_byte_start = r[19];
      byte_done = r[20]; sw_stop = r[21] & r[22] & r[23]; sw_tc_clr = r[24];
      tick();
    end
    @(posedge clk); #3;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule